// File: doc/BRIEF.md
# Four-Way Page Translation Buffer

This block maps 32-bit virtual addresses onto physical addresses for 4 KB pages. It holds 64 translations arranged as 16 sets of four ways. A lookup takes the page number of the virtual address, picks a set, compares the stored tags of that set, and on a match substitutes the stored physical page number. The 12-bit page offset always passes straight through. Lookup results are combinational in the same cycle as the request.

Translations are loaded one per cycle through a refill port. The refill picks its way inside the addressed set in this order: a way that already holds the same tag, then an empty way, then the way named by a 3-bit tree pseudo-LRU pointer kept per set. Each entry stores a parity bit for its tag and one for its physical page number. A lookup that matches a corrupted entry is reported as a parity error and never as a hit. A flush input empties the whole table in one clock.

Top module: `xlate_tlb4`

## Requirements
- R1: During a lookup, `lk_pa[11:0]` equals `lk_va[11:0]`. On a hit, `lk_pa[31:12]` is the stored physical page number. Otherwise `lk_pa[31:12]` is zero.
- R2: The set is selected by `lk_va[15:12]` and the tag is `lk_va[31:16]`. A hit needs a valid way in that set whose tag is equal. The same tag stored in another set does not hit.
- R3: When no valid way of the set holds the refill tag, a refill goes to the lowest-numbered invalid way of the set.
- R4: A refill whose tag is already valid in its set overwrites that way, so the tag is never held twice and the new page number is returned afterwards.
- R5: When all four ways are valid and none matches, the victim is chosen from pointer bits b0..b2 as follows. If b0=0, the victim is way b1 (way 0 or way 1). If b0=1, the victim is way 2+b2.
- R6: A hit or a refill on way w updates the pointer to point away from w. For w<2 this sets b0=1 and b1=(w==0). For w>=2 this sets b0=0 and b2=(w==2). The third bit is left unchanged.
- R7: Even parity is stored for the tag and for the page number. `rf_flip[0]` inverts the stored tag parity and `rf_flip[1]` inverts the stored data parity. A lookup that matches an entry with a parity mismatch drives `lk_perr`=1 and `lk_hit`=0, and it leaves the pointer unchanged.
- R8: After a cycle with `flush` high, every entry is invalid and every pointer is zero. A refill in that same cycle is discarded.
- R9: After reset, every entry is invalid and every pointer is zero.
- R10: With `lk_en` low, `lk_hit` and `lk_perr` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_en | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_pa | output | 32 | Translated physical address |
| lk_hit | output | 1 | Lookup hit |
| lk_perr | output | 1 | Matching entry failed its parity check |
| rf_en | input | 1 | Refill strobe |
| rf_va | input | 32 | Virtual address being installed |
| rf_ppn | input | 20 | Physical page number being installed |
| rf_flip | input | 2 | Parity inversion for the installed entry (bit 0 tag, bit 1 data) |

## Verification
The first phase fills every way of all 16 sets and then sweeps all 64 lookups with varied offsets. This separates correct index and tag slicing from aliasing, because equal tags are placed in neighbouring sets. Directed refills into full sets then show whether the victim follows the pointer. Interleaved hits between refills show whether the pointer moves away from the touched way. Repeated tags separate overwrite from duplication. Corrupted refills show whether the parity check wins over the hit and leaves the pointer untouched. A long pseudo-random mix of lookups and refills, over few sets and few tags, compares every result with a bench model built from the requirements.

// File: rtl/xlate_tlb4.sv
module xlate_tlb4 #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int SETS  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  lk_en,
  input  logic [VA_W-1:0]       lk_va,
  output logic [PA_W-1:0]       lk_pa,
  output logic                  lk_hit,
  output logic                  lk_perr,
  input  logic                  rf_en,
  input  logic [VA_W-1:0]       rf_va,
  input  logic [PA_W-OFF_W-1:0] rf_ppn,
  input  logic [1:0]            rf_flip
);
  localparam int WAYS  = 4;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VA_W - OFF_W - IDX_W;
  localparam int PPN_W = PA_W - OFF_W;

  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q  [SETS][WAYS];
  logic [WAYS-1:0]  vld_q  [SETS];
  logic [WAYS-1:0]  tpar_q [SETS];
  logic [WAYS-1:0]  dpar_q [SETS];
  logic [2:0]       lru_q  [SETS];

  function automatic logic [1:0] plru_victim(input logic [2:0] b);
    return b[0] ? {1'b1, b[2]} : {1'b0, b[1]};
  endfunction

  function automatic logic [2:0] plru_touch(input logic [2:0] b, input logic [1:0] w);
    logic [2:0] r;
    r = b;
    r[0] = ~w[1];
    if (!w[1]) r[1] = ~w[0];
    else       r[2] = ~w[0];
    return r;
  endfunction

  wire [IDX_W-1:0] lk_idx = lk_va[OFF_W +: IDX_W];
  wire [TAG_W-1:0] lk_tag = lk_va[VA_W-1 -: TAG_W];
  wire [IDX_W-1:0] rf_idx = rf_va[OFF_W +: IDX_W];
  wire [TAG_W-1:0] rf_tag = rf_va[VA_W-1 -: TAG_W];

  logic             lk_match, lk_bad;
  logic [1:0]       lk_way;
  logic [PPN_W-1:0] lk_ppn;

  always_comb begin
    lk_match = 1'b0;
    lk_bad   = 1'b0;
    lk_way   = 2'd0;
    lk_ppn   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[lk_idx][w] && tag_q[lk_idx][w] == lk_tag) begin
        lk_match = 1'b1;
        lk_way   = w[1:0];
        lk_ppn   = ppn_q[lk_idx][w];
        lk_bad   = ((^tag_q[lk_idx][w]) != tpar_q[lk_idx][w]) ||
                   ((^ppn_q[lk_idx][w]) != dpar_q[lk_idx][w]);
      end
    end
  end

  assign lk_hit  = lk_en && lk_match && !lk_bad;
  assign lk_perr = lk_en && lk_match && lk_bad;
  assign lk_pa   = {lk_hit ? lk_ppn : {PPN_W{1'b0}}, lk_va[OFF_W-1:0]};

  logic       rf_has, rf_free;
  logic [1:0] rf_same, rf_empty, rf_way;

  always_comb begin
    rf_has   = 1'b0;
    rf_free  = 1'b0;
    rf_same  = 2'd0;
    rf_empty = 2'd0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld_q[rf_idx][w] && tag_q[rf_idx][w] == rf_tag) begin
        rf_has  = 1'b1;
        rf_same = w[1:0];
      end
      if (!vld_q[rf_idx][w]) begin
        rf_free  = 1'b1;
        rf_empty = w[1:0];
      end
    end
    rf_way = rf_has ? rf_same : rf_free ? rf_empty : plru_victim(lru_q[rf_idx]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        lru_q[s] <= 3'b000;
      end
    end else begin
      if (lk_hit && !(rf_en && rf_idx == lk_idx))
        lru_q[lk_idx] <= plru_touch(lru_q[lk_idx], lk_way);
      if (rf_en) begin
        tag_q[rf_idx][rf_way]  <= rf_tag;
        ppn_q[rf_idx][rf_way]  <= rf_ppn;
        vld_q[rf_idx][rf_way]  <= 1'b1;
        tpar_q[rf_idx][rf_way] <= (^rf_tag) ^ rf_flip[0];
        dpar_q[rf_idx][rf_way] <= (^rf_ppn) ^ rf_flip[1];
        lru_q[rf_idx]          <= plru_touch(lru_q[rf_idx], rf_way);
      end
    end
  end
endmodule

module xlate_tlb4_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flush,
  input logic                  lk_en,
  input logic [VA_W-1:0]       lk_va,
  input logic [PA_W-1:0]       lk_pa,
  input logic                  lk_hit,
  input logic                  lk_perr,
  input logic                  rf_en,
  input logic [VA_W-1:0]       rf_va,
  input logic [PA_W-OFF_W-1:0] rf_ppn,
  input logic [1:0]            rf_flip
);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |-> (!lk_hit && !lk_perr));

  a_r7_err_not_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_perr));

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!lk_hit && !lk_perr));

  a_r1_refill_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_en && !flush && rf_flip == 2'b00) |=>
      (!(lk_en && lk_va[VA_W-1:OFF_W] == $past(rf_va[VA_W-1:OFF_W])) ||
       (lk_hit && lk_pa[PA_W-1:OFF_W] == $past(rf_ppn))));
endmodule

bind xlate_tlb4 xlate_tlb4_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lk_en(lk_en), .lk_va(lk_va),
  .lk_pa(lk_pa), .lk_hit(lk_hit), .lk_perr(lk_perr), .rf_en(rf_en),
  .rf_va(rf_va), .rf_ppn(rf_ppn), .rf_flip(rf_flip)
);

// File: tb/sim_xlate_tlb4.sv
`timescale 1ns/1ps
module sim_xlate_tlb4;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_en = 1'b0;
  logic [31:0] lk_va = '0;
  logic [31:0] lk_pa;
  logic        lk_hit, lk_perr;
  logic        rf_en = 1'b0;
  logic [31:0] rf_va = '0;
  logic [19:0] rf_ppn = '0;
  logic [1:0]  rf_flip = '0;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  xlate_tlb4 u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_en(lk_en), .lk_va(lk_va),
    .lk_pa(lk_pa), .lk_hit(lk_hit), .lk_perr(lk_perr), .rf_en(rf_en),
    .rf_va(rf_va), .rf_ppn(rf_ppn), .rf_flip(rf_flip)
  );

  logic [15:0] m_tag [16][4];
  logic [19:0] m_ppn [16][4];
  bit          m_vld [16][4];
  bit          m_bad [16][4];
  logic [2:0]  m_lru [16];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic m_clear();
    for (int s = 0; s < 16; s++) begin
      m_lru[s] = 3'b000;
      for (int w = 0; w < 4; w++) begin
        m_vld[s][w] = 1'b0;
        m_bad[s][w] = 1'b0;
      end
    end
  endtask

  task automatic m_touch(input int s, input int w);
    if (w < 2) begin
      m_lru[s][0] = 1'b1;
      m_lru[s][1] = (w == 0);
    end else begin
      m_lru[s][0] = 1'b0;
      m_lru[s][2] = (w == 2);
    end
  endtask

  function automatic int m_find(input int s, input logic [15:0] t);
    for (int w = 0; w < 4; w++)
      if (m_vld[s][w] && m_tag[s][w] == t) return w;
    return -1;
  endfunction

  task automatic lookup(input logic [31:0] va, input string req);
    int s, w;
    bit eh, ee;
    logic [31:0] ep;
    s = int'(va[15:12]);
    w = m_find(s, va[31:16]);
    eh = (w >= 0) && !m_bad[s][w];
    ee = (w >= 0) && m_bad[s][w];
    ep = {eh ? m_ppn[s][w] : 20'd0, va[11:0]};
    @(negedge clk);
    lk_en = 1'b1;
    lk_va = va;
    #2;
    check(lk_hit == eh && lk_perr == ee && lk_pa == ep, req,
          {30'd0, lk_hit, lk_perr, lk_pa}, {30'd0, eh, ee, ep});
    @(posedge clk);
    #1 lk_en = 1'b0;
    if (eh) m_touch(s, w);
  endtask

  task automatic refill(input logic [31:0] va, input logic [19:0] ppn, input logic [1:0] flip);
    int s, w;
    s = int'(va[15:12]);
    w = m_find(s, va[31:16]);
    if (w < 0)
      for (int k = 3; k >= 0; k--) if (!m_vld[s][k]) w = k;
    if (w < 0)
      w = m_lru[s][0] ? (m_lru[s][2] ? 3 : 2) : (m_lru[s][1] ? 1 : 0);
    @(negedge clk);
    rf_en = 1'b1;
    rf_va = va;
    rf_ppn = ppn;
    rf_flip = flip;
    @(posedge clk);
    #1 rf_en = 1'b0;
    rf_flip = 2'b00;
    m_tag[s][w] = va[31:16];
    m_ppn[s][w] = ppn;
    m_vld[s][w] = 1'b1;
    m_bad[s][w] = (flip != 2'b00);
    m_touch(s, w);
  endtask

  function automatic logic [31:0] mkva(input int tag, input int s, input int off);
    return {tag[15:0], s[3:0], off[11:0]};
  endfunction

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] lcg;
    m_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9: empty after reset
    for (int s = 0; s < 16; s += 5) lookup(mkva(s, s, 16'h0), "R9");

    // R3: fill each set through its free ways; equal tags in neighbouring sets
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++)
        refill(mkva(w + (s % 2), s, 0), 20'(s * 64 + w * 7 + 3), 2'b00);

    // R1 R2: every entry, varied offsets
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++)
        lookup(mkva(w + (s % 2), s, s * 251 + w * 17), "R1_R2");
    lookup(mkva(4, 0, 5), "R2");
    lookup(mkva(0, 1, 5), "R2");

    // R10: idle lookup on a valid entry
    @(negedge clk);
    lk_va = mkva(0, 0, 0);
    lk_en = 1'b0;
    #2 check(!lk_hit && !lk_perr && lk_pa[31:12] == 20'd0, "R10",
             {62'd0, lk_hit, lk_perr}, 64'd0);

    // R5: full set evicts along the pointer
    refill(mkva(100, 2, 0), 20'hABCDE, 2'b00);
    lookup(mkva(2, 2, 0), "R5");
    lookup(mkva(100, 2, 0), "R5");

    // R6: a hit steers the next victim
    lookup(mkva(1, 4, 0), "R6");
    refill(mkva(101, 4, 0), 20'h11111, 2'b00);
    refill(mkva(102, 4, 0), 20'h22222, 2'b00);
    for (int t = 0; t < 4; t++) lookup(mkva(t, 4, 0), "R6");
    lookup(mkva(101, 4, 0), "R6");
    lookup(mkva(102, 4, 0), "R6");

    // R4: same tag overwrites
    refill(mkva(1, 6, 0), 20'h5A5A5, 2'b00);
    for (int t = 0; t < 4; t++) lookup(mkva(t, 6, 9), "R4");

    // R7: corrupt tag and data parity
    refill(mkva(200, 8, 0), 20'h0F0F0, 2'b01);
    lookup(mkva(200, 8, 3), "R7");
    refill(mkva(201, 8, 0), 20'h30303, 2'b10);
    lookup(mkva(201, 8, 3), "R7");
    refill(mkva(202, 8, 0), 20'h44444, 2'b00);
    for (int t = 0; t < 4; t++) lookup(mkva(t, 8, 1), "R7");
    lookup(mkva(202, 8, 1), "R7");

    // R8: flush with a concurrent refill
    @(negedge clk);
    flush = 1'b1;
    rf_en = 1'b1;
    rf_va = mkva(300, 3, 0);
    rf_ppn = 20'h77777;
    @(posedge clk);
    #1 flush = 1'b0;
    rf_en = 1'b0;
    m_clear();
    lookup(mkva(300, 3, 0), "R8");
    for (int s = 0; s < 16; s += 3) lookup(mkva(s % 2, s, 0), "R8");

    // R3 R5 R6: mixed traffic against the model
    lcg = 32'h1234_5678;
    for (int i = 0; i < 3000; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      if (lcg[31:30] == 2'b00)
        refill(mkva(int'(lcg[20:18]) % 6, int'(lcg[17:16]), 0), lcg[19:0], 2'b00);
      else
        lookup(mkva(int'(lcg[20:18]) % 6, int'(lcg[17:16]), int'(lcg[11:0])), "R5_R6");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule